// File: doc/BRIEF.md
# Two-Level Page Table Refill Walker

This block is started after a translation lookaside buffer has no entry for a virtual address. It takes the faulting address, whether the access was a write, a page directory pointer and a software-bit shift amount. It then reads the page directory word, reads an even/odd pair of page table words, and shifts both right to drop the software-only bits. The two shifted words are written into the TLB as the entry-lo pair, together with the pair's virtual page tag. Finally the block reports the outcome of the original access against the refilled entry.

Both table pointers are virtual addresses in the unmapped kernel window. The walker makes them physical by subtracting a fixed base. Memory is reached through a single-outstanding request/response port: the walker holds a request and its address until a response arrives. A zero directory pointer means no table is installed. In that case the walk finishes at once with no reads and a no-match result.

Top module: `pt_walk_unit`

## Requirements
- R1: While reset is held, and whenever the block is idle, `busy_o`, `mem_req_o`, `tlb_we_o` and `done_o` are low.
- R2: A start with `dir_ptr_i` equal to zero produces no memory request and no TLB write. `done_o` is raised on the next cycle with `result_o` = 1 (no match) and `pa_o` = 0.
- R3: The first read address is (`dir_ptr_i` − 0x80000000) + 4 × VA[31:22].
- R4: With P the word returned by the first read, the second read address is (P − 0x80000000) + 8 × VA[21:13]. The third read address is 4 above the second.
- R5: `mem_req_o` stays high and `mem_addr_o` stays unchanged from the cycle a request is raised until the cycle `mem_valid_i` is seen.
- R6: After the third response, `tlb_we_o` pulses for exactly one cycle. During that cycle `tlb_vpn2_o` = VA[31:13], `tlb_lo0_o` = second response >> `sw_shift_i`, and `tlb_lo1_o` = third response >> `sw_shift_i`. The shift is a logical shift.
- R7: VA[12] selects lo1 when set and lo0 when clear. If the selected word has bit 1 (valid) set, and the access is a read or bit 2 (dirty) is set, the result is 0 (match). `pa_o` is then {selected[25:6], VA[11:0]}, which is the page frame number (bits 6 and up) shifted left by 12, plus the page offset.
- R8: If bit 1 of the selected word is clear, the result is 2 (invalid) and `pa_o` is 0.
- R9: A write to a valid selected word with bit 2 clear gives result 3 (modify) and `pa_o` is 0.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The walk in progress keeps its address, access type and pointer.
- R11: `busy_o` is high from the cycle after an accepted start through the cycle `done_o` is high. `done_o` lasts one cycle, and `busy_o` is low on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| va_i | input | 32 | Faulting virtual address |
| is_write_i | input | 1 | Access was a store |
| dir_ptr_i | input | 32 | Page directory base, kernel virtual |
| sw_shift_i | input | 5 | Software-bit shift applied to each table word |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Physical read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Read data |
| tlb_we_o | output | 1 | TLB write strobe |
| tlb_vpn2_o | output | 19 | Virtual page pair tag |
| tlb_lo0_o | output | 32 | Even entry-lo |
| tlb_lo1_o | output | 32 | Odd entry-lo |
| done_o | output | 1 | Result valid (one cycle) |
| result_o | output | 2 | 0 match, 1 no match, 2 invalid, 3 modify |
| pa_o | output | 32 | Physical address on match, else 0 |

## Verification
The walks choose addresses whose VA[12] points at the even word in some cases and at the odd word in others. In each case the other half of the pair carries contradicting valid and dirty bits, so a wrong half selection changes the reported result. Read and write accesses run against dirty and clean pages, which separates match from modify, and pages with bit 1 clear give invalid. Each read address is compared against the expected value, so directory and page-table indexing errors are caught. The low and maximum index values check the pointer rebasing at its edges. Memory latency varies from zero to three cycles to exercise the request hold. The shift amount alternates between 5 and 6 under garbage low bits. A second start injected mid-walk with a different address must leave the result untouched.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int LO_V_BIT   = 1;
  localparam int LO_D_BIT   = 2;
  localparam int LO_PFN_LSB = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_EVEN,
    ST_RD_ODD,
    ST_FILL,
    ST_DONE
  } walk_st_t;

  typedef enum logic [1:0] {
    RES_HIT     = 2'd0,
    RES_MISS    = 2'd1,
    RES_INVALID = 2'd2,
    RES_MODIFY  = 2'd3
  } walk_res_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import pt_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DIR_IDX_W = 10,
  parameter int PT_IDX_W = 9,
  parameter logic [AW-1:0] KSEG_BASE = 32'h8000_0000
) (
  input  walk_st_t             st,
  input  logic [AW-1:0]        dir_ptr,
  input  logic [AW-1:0]        pt_ptr,
  input  logic [DIR_IDX_W-1:0] dir_idx,
  input  logic [PT_IDX_W-1:0]  pt_idx,
  output logic [AW-1:0]        addr
);
  // Kernel-window virtual pointer to physical.
  function automatic logic [AW-1:0] rebase(input logic [AW-1:0] p);
    return p - KSEG_BASE;
  endfunction

  logic [AW-1:0] dir_off, pair_off;
  assign dir_off  = AW'({dir_idx, 2'b00});
  assign pair_off = AW'({pt_idx, 3'b000});

  always_comb begin
    case (st)
      ST_RD_DIR:  addr = rebase(dir_ptr) + dir_off;
      ST_RD_EVEN: addr = rebase(pt_ptr) + pair_off;
      ST_RD_ODD:  addr = rebase(pt_ptr) + pair_off + AW'(4);
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/ptw_pte_conv.sv
module ptw_pte_conv #(
  parameter int AW = 32,
  parameter int SHIFT_W = 5
) (
  input  logic [AW-1:0]      raw,
  input  logic [SHIFT_W-1:0] sh,
  output logic [AW-1:0]      lo
);
  assign lo = raw >> sh;
endmodule

// File: rtl/ptw_judge.sv
module ptw_judge
  import pt_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [PAGE_SHIFT:0] va_low,
  input  logic                wr,
  input  logic [AW-1:0]       lo_even,
  input  logic [AW-1:0]       lo_odd,
  output walk_res_t           res,
  output logic [AW-1:0]       pa
);
  logic [AW-1:0] sel_lo;
  assign sel_lo = va_low[PAGE_SHIFT] ? lo_odd : lo_even;

  always_comb begin
    res = RES_HIT;
    pa  = '0;
    if (!sel_lo[LO_V_BIT]) begin
      res = RES_INVALID;
    end else if (wr && !sel_lo[LO_D_BIT]) begin
      res = RES_MODIFY;
    end else begin
      pa = ((sel_lo >> LO_PFN_LSB) << PAGE_SHIFT) | AW'(va_low[PAGE_SHIFT-1:0]);
    end
  end
endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
  import pt_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int SHIFT_W = 5,
  parameter int PT_IDX_W = 9,
  parameter logic [AW-1:0] KSEG_BASE = 32'h8000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [AW-1:0]      va_i,
  input  logic               is_write_i,
  input  logic [AW-1:0]      dir_ptr_i,
  input  logic [SHIFT_W-1:0] sw_shift_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [AW-1:0]      mem_data_i,
  output logic               tlb_we_o,
  output logic [AW-PAGE_SHIFT-2:0] tlb_vpn2_o,
  output logic [AW-1:0]      tlb_lo0_o,
  output logic [AW-1:0]      tlb_lo1_o,
  output logic               done_o,
  output logic [1:0]         result_o,
  output logic [AW-1:0]      pa_o
);
  localparam int PT_LSB    = PAGE_SHIFT + 1;
  localparam int DIR_LSB   = PT_LSB + PT_IDX_W;
  localparam int DIR_IDX_W = AW - DIR_LSB;

  walk_st_t           state;
  logic [AW-1:0]      va_q, dir_q, pt_q, lo0_q, lo1_q, pa_q;
  logic               wr_q;
  logic [SHIFT_W-1:0] shift_q;
  walk_res_t          res_q;

  // Named internal events
  logic      accept, take_resp;
  logic [AW-1:0] conv_lo, judge_pa;
  walk_res_t judge_res;

  assign accept    = start_i && (state == ST_IDLE);
  assign take_resp = mem_req_o && mem_valid_i;

  ptw_addr_gen #(
    .AW(AW), .DIR_IDX_W(DIR_IDX_W), .PT_IDX_W(PT_IDX_W), .KSEG_BASE(KSEG_BASE)
  ) u_addr (
    .st(state), .dir_ptr(dir_q), .pt_ptr(pt_q),
    .dir_idx(va_q[AW-1:DIR_LSB]), .pt_idx(va_q[DIR_LSB-1:PT_LSB]),
    .addr(mem_addr_o)
  );

  ptw_pte_conv #(.AW(AW), .SHIFT_W(SHIFT_W)) u_conv (
    .raw(mem_data_i), .sh(shift_q), .lo(conv_lo)
  );

  ptw_judge #(.AW(AW)) u_judge (
    .va_low(va_q[PAGE_SHIFT:0]), .wr(wr_q), .lo_even(lo0_q), .lo_odd(lo1_q),
    .res(judge_res), .pa(judge_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      dir_q   <= '0;
      pt_q    <= '0;
      lo0_q   <= '0;
      lo1_q   <= '0;
      pa_q    <= '0;
      wr_q    <= 1'b0;
      shift_q <= '0;
      res_q   <= RES_MISS;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          va_q    <= va_i;
          wr_q    <= is_write_i;
          dir_q   <= dir_ptr_i;
          shift_q <= sw_shift_i;
          if (dir_ptr_i == '0) begin
            res_q <= RES_MISS;
            pa_q  <= '0;
            state <= ST_DONE;
          end else begin
            state <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: if (take_resp) begin
          pt_q  <= mem_data_i;
          state <= ST_RD_EVEN;
        end
        ST_RD_EVEN: if (take_resp) begin
          lo0_q <= conv_lo;
          state <= ST_RD_ODD;
        end
        ST_RD_ODD: if (take_resp) begin
          lo1_q <= conv_lo;
          state <= ST_FILL;
        end
        ST_FILL: begin
          res_q <= judge_res;
          pa_q  <= judge_pa;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state != ST_IDLE);
  assign mem_req_o  = (state == ST_RD_DIR) || (state == ST_RD_EVEN) || (state == ST_RD_ODD);
  assign tlb_we_o   = (state == ST_FILL);
  assign tlb_vpn2_o = va_q[AW-1:PT_LSB];
  assign tlb_lo0_o  = lo0_q;
  assign tlb_lo1_o  = lo1_q;
  assign done_o     = (state == ST_DONE);
  assign result_o   = res_q;
  assign pa_o       = pa_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !tlb_we_o && !done_o));

  assert_zero_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && dir_ptr_i == '0) |=> (done_o && result_o == 2'd1 && !mem_req_o));

  assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fill_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we_o |=> (!tlb_we_o && done_o));

  assert_fault_pa_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o != 2'd0) |-> (pa_o == '0));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> $stable(tlb_vpn2_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/pt_walk_unit_test.sv
`timescale 1ns/1ps
module pt_walk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        is_write_i = 1'b0;
  logic [31:0] dir_ptr_i = '0;
  logic [4:0]  sw_shift_i = '0;
  logic        busy_o, mem_req_o, mem_valid_i, tlb_we_o, done_o;
  logic [31:0] mem_addr_o, mem_data_i, tlb_lo0_o, tlb_lo1_o, pa_o;
  logic [18:0] tlb_vpn2_o;
  logic [1:0]  result_o;

  always #2 clk = ~clk;

  pt_walk_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
    .is_write_i(is_write_i), .dir_ptr_i(dir_ptr_i), .sw_shift_i(sw_shift_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .tlb_we_o(tlb_we_o),
    .tlb_vpn2_o(tlb_vpn2_o), .tlb_lo0_o(tlb_lo0_o), .tlb_lo1_o(tlb_lo1_o),
    .done_o(done_o), .result_o(result_o), .pa_o(pa_o)
  );

  typedef struct {
    string       tag;
    logic [1:0]  res;
    logic [31:0] pa, lo0, lo1, a0, a1, a2;
    logic [18:0] vpn2;
    int          nreq, nfill;
  } exp_t;

  exp_t        q[$];
  exp_t        mon_e;
  logic [31:0] mem [int unsigned];
  logic [31:0] seen[$];
  int n_chk = 0, n_bad = 0;
  int mem_lat = 1, req_cnt = 0, fill_cnt = 0, hold_err = 0, done_cnt = 0;
  bit post_done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory responder: one outstanding read, variable latency
  initial begin
    logic [31:0] a;
    mem_valid_i = 1'b0;
    mem_data_i  = '0;
    forever begin
      @(negedge clk);
      mem_valid_i = 1'b0;
      if (rst_n && mem_req_o) begin
        a = mem_addr_o;
        seen.push_back(a);
        req_cnt++;
        for (int k = 0; k < mem_lat; k++) begin
          @(negedge clk);
          if (!mem_req_o || mem_addr_o !== a) hold_err++;
        end
        mem_data_i  = mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
        mem_valid_i = 1'b1;
      end
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (post_done) begin
      post_done = 0;
      chk("R11 busy low after done", {31'b0, busy_o}, 32'd0);
      chk("R11 done lasts one cycle", {31'b0, done_o}, 32'd0);
    end
    if (rst_n && tlb_we_o) begin
      fill_cnt++;
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected fill: actual 1 expected 0");
      end else begin
        mon_e = q[0];
        chk({"R6 vpn2 ", mon_e.tag}, {13'b0, tlb_vpn2_o}, {13'b0, mon_e.vpn2});
        chk({"R6 lo0 ", mon_e.tag}, tlb_lo0_o, mon_e.lo0);
        chk({"R6 lo1 ", mon_e.tag}, tlb_lo1_o, mon_e.lo1);
      end
    end
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 unexpected done: actual 1 expected 0");
      end else begin
        mon_e = q.pop_front();
        chk({"R7/R8/R9 result ", mon_e.tag}, {30'b0, result_o}, {30'b0, mon_e.res});
        chk({"R7 pa ", mon_e.tag}, pa_o, mon_e.pa);
        chk({"R2 read count ", mon_e.tag}, req_cnt, mon_e.nreq);
        chk({"R6 fill count ", mon_e.tag}, fill_cnt, mon_e.nfill);
        if (mon_e.nreq == 3 && seen.size() == 3) begin
          chk({"R3 dir addr ", mon_e.tag}, seen[0], mon_e.a0);
          chk({"R4 even addr ", mon_e.tag}, seen[1], mon_e.a1);
          chk({"R4 odd addr ", mon_e.tag}, seen[2], mon_e.a2);
        end
        chk({"R5 addr held ", mon_e.tag}, hold_err, 0);
        chk({"R11 busy during done ", mon_e.tag}, {31'b0, busy_o}, 32'd1);
      end
      req_cnt = 0; fill_cnt = 0; hold_err = 0;
      seen.delete();
      done_cnt++;
      post_done = 1;
    end
  end

  task automatic walk(input string tag, input logic [31:0] va, input bit wr,
                      input logic [31:0] dir, input logic [4:0] sh,
                      input logic [31:0] ptv, input logic [31:0] lo_e,
                      input logic [31:0] lo_o, input int lat, input bit poke);
    exp_t e;
    logic [31:0] pe, po, sel, junk_mask;
    int target;
    junk_mask = (32'h1 << sh) - 32'h1;
    pe = (lo_e << sh) | (32'h15A5_5A5A & junk_mask);
    po = (lo_o << sh) | (32'h2B3C_A5C3 & junk_mask);
    e.tag = tag; e.pa = '0; e.lo0 = '0; e.lo1 = '0;
    e.a0 = '0; e.a1 = '0; e.a2 = '0; e.vpn2 = va[31:13];
    mem_lat = lat;
    if (dir == 32'h0) begin
      e.res = 2'd1; e.nreq = 0; e.nfill = 0;
    end else begin
      e.a0 = dir - 32'h8000_0000 + (va >> 22) * 4;
      e.a1 = ptv - 32'h8000_0000 + ((va >> 13) & 32'h1FF) * 8;
      e.a2 = e.a1 + 32'd4;
      mem[e.a0] = ptv; mem[e.a1] = pe; mem[e.a2] = po;
      e.lo0 = pe >> sh; e.lo1 = po >> sh;
      e.nreq = 3; e.nfill = 1;
      sel = va[12] ? e.lo1 : e.lo0;
      if (sel[1] == 1'b0) e.res = 2'd2;
      else if (wr && sel[2] == 1'b0) e.res = 2'd3;
      else begin
        e.res = 2'd0;
        e.pa  = {sel[25:6], va[11:0]};
      end
    end
    q.push_back(e);
    target = done_cnt + 1;
    @(negedge clk);
    start_i = 1'b1; va_i = va; is_write_i = wr; dir_ptr_i = dir; sw_shift_i = sh;
    @(negedge clk);
    start_i = 1'b0;
    chk({"R11 busy after start ", tag}, {31'b0, busy_o}, 32'd1);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1; va_i = ~va; is_write_i = ~wr; dir_ptr_i = 32'h0; sw_shift_i = ~sh;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy_o}, 32'd0);
    chk("R1 req in reset", {31'b0, mem_req_o}, 32'd0);
    chk("R1 tlb_we in reset", {31'b0, tlb_we_o}, 32'd0);
    chk("R1 done in reset", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {29'b0, busy_o, mem_req_o, done_o}, 32'd0);

    walk("R2 zero dir read",  32'h0040_1000, 0, 32'h0, 5'd6, 32'h0, 0, 0, 1, 0);
    walk("R2 zero dir write", 32'hC000_0000, 1, 32'h0, 5'd5, 32'h0, 0, 0, 0, 0);
    walk("R7 even read hit",  32'h1234_4678, 0, 32'h8010_0000, 5'd6, 32'h8020_0000,
         32'h0003_4546, 32'h0000_0000, 1, 0);
    walk("R7 odd read hit",   32'h0804_3ABC, 0, 32'h8011_0000, 5'd6, 32'h8022_0000,
         32'h0000_0000, 32'h0001_2342, 0, 0);
    walk("R9 write clean page", 32'h7FF0_2000, 1, 32'h8012_0000, 5'd5, 32'h8030_0000,
         32'h0000_ABC2, 32'h0000_0006, 2, 0);
    walk("R7 write dirty page", 32'h7FF0_3000, 1, 32'h8012_0000, 5'd5, 32'h8030_0000,
         32'h0000_0002, 32'h0000_7786, 3, 0);
    walk("R8 odd invalid",    32'h0000_1000, 0, 32'h8013_0000, 5'd6, 32'h8040_0000,
         32'h0000_0046, 32'h0000_0044, 1, 0);
    walk("R8 even invalid write", 32'h0050_0234, 1, 32'h8013_0000, 5'd6, 32'h8040_0000,
         32'h0000_0000, 32'h0000_0006, 2, 0);
    walk("R6 shift five max index", 32'hFFFF_EFFF, 0, 32'hA000_0000, 5'd5, 32'h8100_0000,
         32'h07FF_FFFE, 32'h0000_0000, 0, 0);
    walk("R3 lowest pointers", 32'h0000_0FFF, 0, 32'h8000_0000, 5'd6, 32'h8000_1000,
         32'h0000_0FC2, 32'h0000_0000, 1, 0);
    walk("R10 start ignored while busy", 32'h2468_0ACE, 0, 32'h8014_0000, 5'd6, 32'h8050_0000,
         32'h0002_2202, 32'h0000_0000, 2, 1);

    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule